// File: doc/BRIEF.md
# Reservation-Aware LRU Victim Selector

This block keeps the replacement state of a set-associative private cache. For every set it holds a recency order of the ways and a reservation mask with one bit per way. A reserved way may hold only lines that enter in the shared state. When a fill request arrives, the block picks the way to evict. A fill that brings in a shared line may evict any way. A fill that brings in a private line may evict only unreserved ways. The tag and data arrays sit outside, along with the coherence machinery and the controller that decides how many ways to reserve.

Each cycle can carry one fill, one hit update (touch) and one mask write. The victim is computed from registered state in the cycle of the request and is presented on registered outputs on the next cycle. The filled way becomes the most recently used way of its set. A touched way does the same.

The mask writer refuses any pattern that reserves every way, so a private fill always finds a candidate. The bench uses WAYS=8 and SETS=16 (`AW` = log2 WAYS, `SW` = log2 SETS). A 16-way build only changes a parameter.

Top module: `rsv_lru_victim`

## Requirements
- R1: After synchronous reset, `victim_valid` and `mask_wr_reject` are 0, every set's mask is all zeros, and every set's recency order runs from way 0 (most recent) to way WAYS-1 (least recent).
- R2: `victim_valid` is 1 exactly in the cycle after a cycle with `fill_req`=1. `victim_way` updates only on such cycles and otherwise holds its value.
- R3: When `fill_shared`=1, the victim is the least recently used way of the addressed set, regardless of its mask.
- R4: When `fill_shared`=0, the victim is the least recently used way among the ways whose mask bit (bit i belongs to way i) is 0.
- R5: A fill makes the chosen victim way the most recently used way of its set. A touch (`touch_en`=1) does the same for `touch_way` in `touch_set`. The relative order of the other ways is kept.
- R6: If a fill and a touch address the same set in one cycle, only the fill updates recency and the touch is dropped. If they address different sets, both take effect.
- R7: A mask write replaces the whole mask of `mask_wr_set` with `mask_wr_data`. A write whose data is all ones is refused: the mask is left unchanged and `mask_wr_reject` is 1 in the following cycle, otherwise 0.
- R8: A fill uses the mask as it stood before the clock edge. A mask write in the same cycle affects only later fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Request a victim for a fill |
| fill_set | input | SW | Set index of the fill |
| fill_shared | input | 1 | 1: incoming line is shared; 0: private |
| touch_en | input | 1 | Hit update enable |
| touch_set | input | SW | Set index of the hit |
| touch_way | input | AW | Way that was hit |
| mask_wr_en | input | 1 | Mask write enable |
| mask_wr_set | input | SW | Set whose mask is written |
| mask_wr_data | input | WAYS | New reservation mask, bit i for way i |
| victim_valid | output | 1 | Victim output valid, one cycle after fill_req |
| victim_way | output | AW | Chosen victim way |
| mask_wr_reject | output | 1 | Previous cycle's mask write was refused |

## Verification
Directed fills right after reset separate the initial ordering from the mask state. Shared and private fills on a set with one reserved LRU way show whether the mask is honoured only for private lines. An all-ones mask write followed by a private fill shows that the refused write left the old mask in place. A fill and a touch on the same set, and then on different sets, separate the collision rule from ordinary dual updates. Long random runs over four sets mix fills, touches and mask writes with frequent collisions, and compare each victim against a list-based recency model.

// File: rtl/rsv_lru_pkg.sv
package rsv_lru_pkg;
  typedef enum logic {
    FILL_PRIVATE = 1'b0,
    FILL_SHARED  = 1'b1
  } fill_kind_e;
endpackage

// File: rtl/rsv_age_promote.sv
// Moves one way to age 0 (most recent); ways that were younger age by one.
module rsv_age_promote #(
  parameter int WAYS = 8,
  localparam int AW = $clog2(WAYS)
) (
  input  logic [WAYS*AW-1:0] ages_in,
  input  logic [AW-1:0]      way,
  output logic [WAYS*AW-1:0] ages_out
);
  logic [AW-1:0] pivot;

  always_comb begin
    pivot = ages_in[way*AW +: AW];
    for (int i = 0; i < WAYS; i++) begin
      if (AW'(i) == way)
        ages_out[i*AW +: AW] = '0;
      else if (ages_in[i*AW +: AW] < pivot)
        ages_out[i*AW +: AW] = ages_in[i*AW +: AW] + AW'(1);
      else
        ages_out[i*AW +: AW] = ages_in[i*AW +: AW];
    end
  end
endmodule

// File: rtl/rsv_victim_pick.sv
// Oldest way among the eligible ones; all ways if none is eligible.
module rsv_victim_pick #(
  parameter int WAYS = 8,
  localparam int AW = $clog2(WAYS)
) (
  input  logic [WAYS*AW-1:0] ages,
  input  logic [WAYS-1:0]    elig,
  output logic [AW-1:0]      way
);
  logic [WAYS-1:0] cand;
  logic [AW-1:0]   best_age;
  logic            found;

  always_comb begin
    cand     = (elig == '0) ? '1 : elig;
    way      = '0;
    best_age = '0;
    found    = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || ages[i*AW +: AW] > best_age)) begin
        found    = 1'b1;
        best_age = ages[i*AW +: AW];
        way      = AW'(i);
      end
    end
  end
endmodule

// File: rtl/rsv_lru_victim.sv
module rsv_lru_victim
  import rsv_lru_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int AW = $clog2(WAYS),
  localparam int SW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fill_req,
  input  logic [SW-1:0]   fill_set,
  input  logic            fill_shared,
  input  logic            touch_en,
  input  logic [SW-1:0]   touch_set,
  input  logic [AW-1:0]   touch_way,
  input  logic            mask_wr_en,
  input  logic [SW-1:0]   mask_wr_set,
  input  logic [WAYS-1:0] mask_wr_data,
  output logic            victim_valid,
  output logic [AW-1:0]   victim_way,
  output logic            mask_wr_reject
);
  logic [WAYS*AW-1:0] age_q  [SETS];
  logic [WAYS-1:0]    mask_q [SETS];

  logic [WAYS-1:0]    fill_mask;
  logic [WAYS-1:0]    elig;
  logic [AW-1:0]      pick_way;
  logic [WAYS*AW-1:0] fill_ages;
  logic [WAYS*AW-1:0] touch_ages;
  logic               touch_apply;
  logic               wr_full;
  fill_kind_e         kind;

  assign fill_mask   = mask_q[fill_set];
  assign kind        = fill_kind_e'(fill_shared);
  assign elig        = (kind == FILL_SHARED) ? '1 : ~fill_mask;
  assign touch_apply = touch_en && !(fill_req && (fill_set == touch_set));
  assign wr_full     = &mask_wr_data;

  rsv_victim_pick #(.WAYS(WAYS)) pick_i (
    .ages (age_q[fill_set]),
    .elig (elig),
    .way  (pick_way)
  );

  rsv_age_promote #(.WAYS(WAYS)) fill_upd_i (
    .ages_in  (age_q[fill_set]),
    .way      (pick_way),
    .ages_out (fill_ages)
  );

  rsv_age_promote #(.WAYS(WAYS)) touch_upd_i (
    .ages_in  (age_q[touch_set]),
    .way      (touch_way),
    .ages_out (touch_ages)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid   <= 1'b0;
      victim_way     <= '0;
      mask_wr_reject <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        mask_q[s] <= '0;
        for (int w = 0; w < WAYS; w++)
          age_q[s][w*AW +: AW] <= AW'(w);
      end
    end else begin
      victim_valid   <= fill_req;
      mask_wr_reject <= mask_wr_en && wr_full;
      if (fill_req) begin
        victim_way      <= pick_way;
        age_q[fill_set] <= fill_ages;
      end
      if (touch_apply)
        age_q[touch_set] <= touch_ages;
      if (mask_wr_en && !wr_full)
        mask_q[mask_wr_set] <= mask_wr_data;
    end
  end
endmodule

// File: rtl/rsv_lru_victim_chk.sv
module rsv_lru_victim_chk #(
  parameter int WAYS = 8,
  localparam int AW = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst,
  input logic            fill_req,
  input logic            fill_shared,
  input logic [WAYS-1:0] fill_mask,
  input logic            mask_wr_en,
  input logic [WAYS-1:0] mask_wr_data,
  input logic            victim_valid,
  input logic [AW-1:0]   victim_way,
  input logic            mask_wr_reject
);
  logic [WAYS-1:0] prev_mask;
  always_ff @(posedge clk) prev_mask <= fill_mask;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> victim_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> !victim_valid);
  assert_way_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> $stable(victim_way));
  assert_private_unreserved_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_shared && !(&fill_mask)) |=> !prev_mask[victim_way]);
  assert_full_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_wr_en && &mask_wr_data) |=> mask_wr_reject);
  assert_no_spurious_reject_R7: assert property (@(posedge clk) disable iff (rst)
    !(mask_wr_en && &mask_wr_data) |=> !mask_wr_reject);
  assert_mask_never_full_R7: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !(&fill_mask));
endmodule

bind rsv_lru_victim rsv_lru_victim_chk #(.WAYS(WAYS)) chk_i (.*);

// File: tb/rsv_lru_victim_tb_top.sv
`timescale 1ns/1ps
module rsv_lru_victim_tb_top;
  localparam int WAYS = 8;
  localparam int SETS = 16;
  localparam int AW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic clk = 1'b0;
  logic rst;
  logic fill_req, fill_shared, touch_en, mask_wr_en;
  logic [SW-1:0] fill_set, touch_set, mask_wr_set;
  logic [AW-1:0] touch_way;
  logic [WAYS-1:0] mask_wr_data;
  logic victim_valid, mask_wr_reject;
  logic [AW-1:0] victim_way;

  always #10 clk = ~clk;

  rsv_lru_victim #(.WAYS(WAYS), .SETS(SETS)) dut_i (.*);

  int checks = 0;
  int fails = 0;
  int ord [SETS][WAYS];          // position 0 = most recent
  logic [WAYS-1:0] mm [SETS];
  int exp_way = 0;

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_pick(int s, bit sh);
    for (int p = WAYS - 1; p >= 0; p--) begin
      int w = ord[s][p];
      if (sh || !mm[s][w] || (&mm[s])) return w;
    end
    return 0;
  endfunction

  function automatic void promote(int s, int w);
    int pos = 0;
    for (int p = 0; p < WAYS; p++) if (ord[s][p] == w) pos = p;
    for (int p = pos; p > 0; p--) ord[s][p] = ord[s][p-1];
    ord[s][0] = w;
  endfunction

  task automatic cyc(bit f, int fs, bit sh, bit t, int ts, int tw,
                     bit mw, int ms, logic [WAYS-1:0] md, string req);
    int ev;
    bit er;
    fill_req = f; fill_set = SW'(fs); fill_shared = sh;
    touch_en = t; touch_set = SW'(ts); touch_way = AW'(tw);
    mask_wr_en = mw; mask_wr_set = SW'(ms); mask_wr_data = md;
    ev = f ? model_pick(fs, sh) : exp_way;
    er = mw && (&md);
    @(posedge clk);
    @(negedge clk);
    check(victim_valid, f, "R2 valid");
    if (f) check(victim_way, ev, req);
    else   check(victim_way, ev, "R2 hold");
    check(mask_wr_reject, er, "R7 reject");
    exp_way = ev;
    if (f) promote(fs, ev);
    if (t && !(f && fs == ts)) promote(ts, tw);
    if (mw && !(&md)) mm[ms] = md;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mm[s] = '0;
      for (int w = 0; w < WAYS; w++) ord[s][w] = w;
    end
    rst = 1'b1;
    fill_req = 0; fill_set = 0; fill_shared = 0; touch_en = 0; touch_set = 0;
    touch_way = 0; mask_wr_en = 0; mask_wr_set = 0; mask_wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(victim_valid, 0, "R1 valid after reset");
    check(mask_wr_reject, 0, "R1 reject after reset");
    rst = 1'b0;

    // R1: initial LRU is way 7, masks clear so private fill takes it
    cyc(1, 1, 0, 0, 0, 0, 0, 0, '0, "R1 private fill after reset");
    check(victim_way, 7, "R1 way");
    // R3: shared fill on set 0 -> way 7
    cyc(1, 0, 1, 0, 0, 0, 0, 0, '0, "R3 shared fill");
    check(victim_way, 7, "R3 way");
    // reserve way 6 (now LRU of set 0)
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 8'b0100_0000, "R7 write");
    // R4: private fill skips reserved LRU way 6 -> way 5
    cyc(1, 0, 0, 0, 0, 0, 0, 0, '0, "R4 private skips reserved");
    check(victim_way, 5, "R4 way");
    // R3: shared fill may take reserved way 6
    cyc(1, 0, 1, 0, 0, 0, 0, 0, '0, "R3 shared takes reserved");
    check(victim_way, 6, "R3 reserved way");
    // R7: all-ones refused; mask unchanged -> private fill still avoids way 6
    cyc(0, 0, 0, 0, 0, 0, 1, 0, '1, "R7 full refused");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, '0, "R7 mask unchanged after refusal");
    // R8: write in same cycle as fill does not affect that fill
    cyc(1, 2, 0, 0, 0, 0, 1, 2, 8'b1000_0000, "R8 old mask used");
    check(victim_way, 7, "R8 way");
    // R5: touch makes way MRU; LRU of set 3 is way 7, touch it then fill
    cyc(0, 0, 0, 1, 3, 7, 0, 0, '0, "R5 touch");
    cyc(1, 3, 1, 0, 0, 0, 0, 0, '0, "R5 touched way not victim");
    check(victim_way, 6, "R5 way");
    // R6: same-set fill and touch -> touch dropped
    cyc(1, 4, 1, 1, 4, 6, 0, 0, '0, "R6 collision fill");
    cyc(1, 4, 1, 0, 0, 0, 0, 0, '0, "R6 touch dropped");
    check(victim_way, 6, "R6 way");
    // R6: different sets both apply
    cyc(1, 5, 1, 1, 6, 7, 0, 0, '0, "R6 dual update");
    cyc(1, 6, 1, 0, 0, 0, 0, 0, '0, "R6 touch applied");
    check(victim_way, 6, "R6 other set way");

    // random mix on four sets
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 1500; i++) begin
      bit f = ($urandom % 2) == 0;
      bit t = ($urandom % 2) == 0;
      bit mw = ($urandom % 10) == 0;
      logic [WAYS-1:0] md = WAYS'($urandom);
      if (($urandom % 4) == 0) md = '1;
      cyc(f, $urandom % 4, $urandom % 2, t, $urandom % 4, $urandom % WAYS,
          mw, $urandom % 4, md, "R3 R4 R5 R6 random victim");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule